// File: doc/BRIEF.md
# DMA Chain-Mode Tag Sequencer

This block is the control state machine of one DMA channel. Software loads a quadword count, a source address and a destination address, picks normal or chain mode, and pulses start. In normal mode the channel issues one burst and completes. In chain mode with a zero count, the channel reads a tag at the source address. The tag supplies the burst length and the destination address. The channel launches that burst and then either fetches the next tag after a fixed pause or completes.

A tag is 128 bits wide, but only its lower 64 bits matter here. The tag read port returns those 64 bits with a request/acknowledge handshake. The burst data lies directly after the tag in the source stream, so the source address moves past both the tag and its data. A stall-capable tag can record where the written data will end, so that another channel can stall on that address. The channel raises its completion interrupt only once no ring-buffer consumer is still draining.

Top module: `chain_tag_seq`

## Requirements
- R1: In chain mode with a nonzero preloaded count, the channel issues one burst of that count at the preloaded destination, reads no tag, and then completes.
- R2: A tag is requested at the current source address. After the tag is taken, the source address advances by 16 plus 16 times the burst count, and the next tag request uses that address.
- R3: On a fetched tag, the burst count comes from bits 15:0 and the destination from bits 63:32. The burst request shows both fields, and a tag read and a burst are never requested together.
- R4: The tag ID is bits 30:28. ID 1 continues the chain and ID 0 continues it with stall handling. ID 7 and every other ID end the chain after that tag's burst.
- R5: A tag with ID 0, taken while the stall-source input is high, sets the stall-address output to destination + 16 × count. Any other tag leaves that output unchanged.
- R6: When tag-interrupt enable is high and tag bit 31 is set, the chain ends after that tag's burst, whatever the ID.
- R7: When the chain continues, the next tag request rises on the fourth clock edge after the edge that accepts burst completion.
- R8: On completion, run_o falls and irq_o pulses high for exactly one cycle. While consumer_busy_i is high, completion waits: run_o stays high and irq_o stays low.
- R9: Normal mode issues one burst of the loaded count and completes. A zero count completes with no burst.
- R10: start_i is ignored while run_o is high.
- R11: After reset run_o, irq_o, tag_req_o and burst_req_o are low and stall_addr_o is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse (accepted only while idle) |
| chain_mode_i | input | 1 | 1 = chain mode, 0 = normal mode |
| tag_irq_en_i | input | 1 | Tag-interrupt enable |
| stall_src_i | input | 1 | Stall control names this channel as source |
| qwc_init_i | input | QWC_W | Preloaded quadword count |
| src_init_i | input | ADDR_W | Preloaded source address |
| dst_init_i | input | ADDR_W | Preloaded destination address |
| tag_req_o | output | 1 | Tag read request |
| tag_addr_o | output | ADDR_W | Tag read address |
| tag_ack_i | input | 1 | Tag data valid / request accepted |
| tag_data_i | input | 64 | Lower 64 bits of the tag |
| burst_req_o | output | 1 | Burst launch request |
| burst_dst_o | output | ADDR_W | Burst destination address |
| burst_qwc_o | output | QWC_W | Burst quadword count |
| burst_done_i | input | 1 | Burst finished |
| consumer_busy_i | input | 1 | Ring-buffer consumer still running |
| run_o | output | 1 | Channel active (start bit) |
| irq_o | output | 1 | One-cycle completion interrupt |
| stall_addr_o | output | ADDR_W | Stall address register |

## Verification
The hardest case to reach from the ports is a chain whose end comes from something other than its ID. Examples are an interrupt-flagged continuing tag, or an unrecognised ID, arriving while completion is also held off by a busy consumer. The bench reaches these cases with a tag responder that serves tags from a table. It sweeps the last tag's ID, the interrupt flag, the interrupt enable and the stall-source select. It holds consumer_busy_i high across the final burst and pulses start_i in the middle of a chain. For every tag it computes the expected addresses, counts, pause length and stall address arithmetically.

// File: rtl/chain_seq_pkg.sv
package chain_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_BURST,
    ST_WAIT,
    ST_FINISH
  } seq_state_t;

  localparam logic [2:0] TAG_ID_CNTS = 3'd0;
  localparam logic [2:0] TAG_ID_CNT  = 3'd1;
  localparam logic [2:0] TAG_ID_END  = 3'd7;
endpackage

// File: rtl/cst_tag_decode.sv
module cst_tag_decode
  import chain_seq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int QWC_W  = 16
) (
  input  logic [63:0]       tag_i,
  input  logic              irq_en_i,
  output logic [QWC_W-1:0]  qwc_o,
  output logic [ADDR_W-1:0] dst_o,
  output logic              last_o,
  output logic              stall_tag_o,
  output logic [ADDR_W-1:0] stall_addr_o
);
  localparam int PAD_W = ADDR_W - QWC_W - 4;

  logic [2:0] id;
  logic       irq_flag;
  logic       keeps_going;

  always_comb begin
    id           = tag_i[30:28];
    irq_flag     = tag_i[31];
    qwc_o        = tag_i[QWC_W-1:0];
    dst_o        = tag_i[32 +: ADDR_W];
    keeps_going  = (id == TAG_ID_CNT) || (id == TAG_ID_CNTS);
    last_o       = !keeps_going || (irq_en_i && irq_flag);
    stall_tag_o  = (id == TAG_ID_CNTS);
    stall_addr_o = dst_o + {{PAD_W{1'b0}}, qwc_o, 4'b0000};
  end
endmodule

// File: rtl/cst_gap_timer.sv
module cst_gap_timer #(
  parameter int GAP = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm_i,
  output logic expire_o
);
  localparam int CNT_W = (GAP > 1) ? $clog2(GAP) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(GAP - 1);

  logic             active_q, active_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    active_d = active_q;
    cnt_d    = cnt_q;
    if (arm_i) begin
      active_d = 1'b1;
      cnt_d    = '0;
    end else if (active_q) begin
      if (cnt_q == LAST) active_d = 1'b0;
      else               cnt_d    = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else begin
      active_q <= active_d;
      cnt_q    <= cnt_d;
    end
  end

  assign expire_o = active_q && (cnt_q == LAST);

  p_expire_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_o && !arm_i) |=> !expire_o);
endmodule

// File: rtl/chain_tag_seq.sv
module chain_tag_seq
  import chain_seq_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int QWC_W     = 16,
  parameter int FETCH_GAP = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              chain_mode_i,
  input  logic              tag_irq_en_i,
  input  logic              stall_src_i,
  input  logic [QWC_W-1:0]  qwc_init_i,
  input  logic [ADDR_W-1:0] src_init_i,
  input  logic [ADDR_W-1:0] dst_init_i,
  output logic              tag_req_o,
  output logic [ADDR_W-1:0] tag_addr_o,
  input  logic              tag_ack_i,
  input  logic [63:0]       tag_data_i,
  output logic              burst_req_o,
  output logic [ADDR_W-1:0] burst_dst_o,
  output logic [QWC_W-1:0]  burst_qwc_o,
  input  logic              burst_done_i,
  input  logic              consumer_busy_i,
  output logic              run_o,
  output logic              irq_o,
  output logic [ADDR_W-1:0] stall_addr_o
);
  localparam int PAD_W = ADDR_W - QWC_W - 4;
  localparam logic [ADDR_W-1:0] TAG_BYTES = ADDR_W'(16);

  seq_state_t        state_q, state_d;
  logic [ADDR_W-1:0] src_q, src_d, dst_q, dst_d, stall_q, stall_d;
  logic [QWC_W-1:0]  qwc_q, qwc_d;
  logic              last_q, last_d, run_q, run_d, irq_q, irq_d;
  logic              arm_gap, gap_expire;

  logic [QWC_W-1:0]  dec_qwc;
  logic [ADDR_W-1:0] dec_dst, dec_stall;
  logic              dec_last, dec_stall_tag;
  logic [ADDR_W-1:0] burst_bytes;

  cst_tag_decode #(.ADDR_W(ADDR_W), .QWC_W(QWC_W)) u_decode (
    .tag_i        (tag_data_i),
    .irq_en_i     (tag_irq_en_i),
    .qwc_o        (dec_qwc),
    .dst_o        (dec_dst),
    .last_o       (dec_last),
    .stall_tag_o  (dec_stall_tag),
    .stall_addr_o (dec_stall)
  );

  cst_gap_timer #(.GAP(FETCH_GAP)) u_gap (
    .clk      (clk),
    .rst_n    (rst_n),
    .arm_i    (arm_gap),
    .expire_o (gap_expire)
  );

  assign burst_bytes = {{PAD_W{1'b0}}, qwc_q, 4'b0000};

  always_comb begin
    state_d = state_q;
    src_d   = src_q;
    dst_d   = dst_q;
    qwc_d   = qwc_q;
    last_d  = last_q;
    run_d   = run_q;
    stall_d = stall_q;
    irq_d   = 1'b0;
    arm_gap = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          run_d  = 1'b1;
          src_d  = src_init_i;
          dst_d  = dst_init_i;
          qwc_d  = qwc_init_i;
          last_d = !(chain_mode_i && (qwc_init_i == '0));
          if (chain_mode_i && (qwc_init_i == '0)) state_d = ST_FETCH;
          else if (qwc_init_i != '0)               state_d = ST_BURST;
          else                                     state_d = ST_FINISH;
        end
      end
      ST_FETCH: begin
        if (tag_ack_i) begin
          src_d  = src_q + TAG_BYTES;
          qwc_d  = dec_qwc;
          dst_d  = dec_dst;
          last_d = dec_last;
          if (dec_stall_tag && stall_src_i) stall_d = dec_stall;
          if (dec_qwc != '0)  state_d = ST_BURST;
          else if (dec_last)  state_d = ST_FINISH;
          else begin
            state_d = ST_WAIT;
            arm_gap = 1'b1;
          end
        end
      end
      ST_BURST: begin
        if (burst_done_i) begin
          src_d = src_q + burst_bytes;
          dst_d = dst_q + burst_bytes;
          qwc_d = '0;
          if (last_q) state_d = ST_FINISH;
          else begin
            state_d = ST_WAIT;
            arm_gap = 1'b1;
          end
        end
      end
      ST_WAIT: begin
        if (gap_expire) state_d = ST_FETCH;
      end
      ST_FINISH: begin
        if (!consumer_busy_i) begin
          run_d   = 1'b0;
          irq_d   = 1'b1;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      src_q   <= '0;
      dst_q   <= '0;
      qwc_q   <= '0;
      last_q  <= 1'b0;
      run_q   <= 1'b0;
      irq_q   <= 1'b0;
      stall_q <= '0;
    end else begin
      state_q <= state_d;
      src_q   <= src_d;
      dst_q   <= dst_d;
      qwc_q   <= qwc_d;
      last_q  <= last_d;
      run_q   <= run_d;
      irq_q   <= irq_d;
      stall_q <= stall_d;
    end
  end

  assign tag_req_o    = (state_q == ST_FETCH);
  assign tag_addr_o   = src_q;
  assign burst_req_o  = (state_q == ST_BURST);
  assign burst_dst_o  = dst_q;
  assign burst_qwc_o  = qwc_q;
  assign run_o        = run_q;
  assign irq_o        = irq_q;
  assign stall_addr_o = stall_q;

  p_req_exclusive_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(tag_req_o && burst_req_o));

  p_tag_to_burst_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tag_req_o && tag_ack_i && (tag_data_i[QWC_W-1:0] != '0)) |=>
      (burst_req_o && (burst_qwc_o == $past(tag_data_i[QWC_W-1:0]))));

  p_irq_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |=> !irq_o);

  p_irq_after_run_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> (!run_o && $past(run_o)));

  p_hold_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_FINISH) && consumer_busy_i) |=> (run_o && !irq_o));

  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !run_o |-> (!tag_req_o && !burst_req_o));
endmodule

// File: tb/chain_tag_seq_tb_top.sv
module chain_tag_seq_tb_top;
  logic        clk, rst_n;
  logic        start_i, chain_mode_i, tag_irq_en_i, stall_src_i;
  logic [15:0] qwc_init_i;
  logic [31:0] src_init_i, dst_init_i;
  logic        tag_req_o, tag_ack_i, burst_req_o, burst_done_i;
  logic [31:0] tag_addr_o, burst_dst_o, stall_addr_o;
  logic [63:0] tag_data_i;
  logic [15:0] burst_qwc_o;
  logic        consumer_busy_i, run_o, irq_o;

  int n_chk, n_bad;
  logic [31:0] exp_stall;

  logic [2:0]  t_id  [4];
  logic        t_irq [4];
  logic [15:0] t_q   [4];
  logic [31:0] t_d   [4];

  chain_tag_seq dut_i (.*);

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic set_tag(input int i, input logic [2:0] id, input logic irq,
                         input logic [15:0] q, input logic [31:0] d);
    t_id[i] = id; t_irq[i] = irq; t_q[i] = q; t_d[i] = d;
  endtask

  task automatic run_seq(input bit chain, input bit tie, input bit ssel, input bit hold,
                         input bit restart, input logic [15:0] q0, input logic [31:0] s0,
                         input logic [31:0] d0, input int exp_fetch, input int exp_bursts,
                         input string rq);
    logic [31:0] e_src, e_dst;
    logic [15:0] e_q;
    bit e_last, fin, final_pend;
    int k, cyc, done_cyc, bcnt, bursts, holdcnt;
    string lbl;
    e_src = s0; e_dst = d0; e_q = q0;
    e_last = !(chain && q0 == 16'd0);
    k = 0; cyc = 0; done_cyc = -1; bcnt = 0; bursts = 0; holdcnt = 0; fin = 0;
    final_pend = (!chain && q0 == 16'd0);
    lbl = restart ? "R2/R10" : "R2";
    @(negedge clk);
    chain_mode_i = chain; tag_irq_en_i = tie; stall_src_i = ssel;
    qwc_init_i = q0; src_init_i = s0; dst_init_i = d0;
    consumer_busy_i = hold; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    while (!fin && cyc < 500) begin
      tag_ack_i = 1'b0;
      burst_done_i = 1'b0;
      if (irq_o) begin
        fin = 1;
        chk(run_o == 1'b0, "R8 run_o low at irq", run_o, 0);
      end else if (tag_req_o) begin
        chk(tag_addr_o == e_src, lbl, tag_addr_o, e_src);
        if (done_cyc >= 0) chk(cyc - done_cyc == 5, "R7 fetch gap", cyc - done_cyc, 5);
        done_cyc = -1;
        tag_data_i = {t_d[k], t_irq[k], t_id[k], 12'h000, t_q[k]};
        tag_ack_i = 1'b1;
        e_src  = e_src + 32'd16;
        e_q    = t_q[k];
        e_dst  = t_d[k];
        e_last = !(t_id[k] == 3'd1 || t_id[k] == 3'd0) || (tie && t_irq[k]);
        if (t_id[k] == 3'd0 && ssel) exp_stall = t_d[k] + {12'h000, t_q[k], 4'h0};
        k++;
        if (restart && k == 1) begin
          start_i = 1'b1; qwc_init_i = 16'd9; src_init_i = 32'h0; dst_init_i = 32'h0;
        end
      end else if (burst_req_o) begin
        bcnt++;
        if (bcnt == 1) begin
          bursts++;
          chk(burst_dst_o == e_dst, chain ? "R3 burst dst" : "R9 burst dst", burst_dst_o, e_dst);
          chk(burst_qwc_o == e_q, (chain && q0 != 0) ? "R1 burst qwc" : "R3 burst qwc", burst_qwc_o, e_q);
        end else begin
          burst_done_i = 1'b1;
          bcnt = 0;
          e_src = e_src + {12'h000, e_q, 4'h0};
          done_cyc = cyc;
          if (e_last) final_pend = 1;
        end
      end else if (final_pend && hold && !burst_done_i) begin
        if (holdcnt > 0) chk(run_o && !irq_o, "R8 held by consumer", {run_o, irq_o}, 2'b10);
        holdcnt++;
        if (holdcnt == 6) consumer_busy_i = 1'b0;
      end
      cyc++;
      if (!fin) begin
        @(negedge clk);
        start_i = 1'b0;
      end
    end
    chk(fin, "R8 completion irq", fin, 1);
    chk(k == exp_fetch, rq, k, exp_fetch);
    chk(bursts == exp_bursts, rq, bursts, exp_bursts);
    if (hold) chk(holdcnt >= 6, "R8 hold observed", holdcnt, 6);
    @(negedge clk);
    chk(irq_o == 1'b0, "R8 irq one cycle", irq_o, 0);
    chk(run_o == 1'b0, "R10 stays idle after run", run_o, 0);
    chk(stall_addr_o == exp_stall, "R5 stall address", stall_addr_o, exp_stall);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(20 * 150000);
    n_bad++;
    $display("FAIL watchdog R8 actual=hang expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    n_chk = 0; n_bad = 0; exp_stall = 32'h0;
    rst_n = 1'b0; start_i = 0; chain_mode_i = 0; tag_irq_en_i = 0; stall_src_i = 0;
    qwc_init_i = 0; src_init_i = 0; dst_init_i = 0; tag_ack_i = 0; tag_data_i = 0;
    burst_done_i = 0; consumer_busy_i = 0;
    for (int i = 0; i < 4; i++) set_tag(i, 3'd7, 1'b0, 16'd1, 32'h0);
    repeat (3) @(negedge clk);
    chk(!run_o && !irq_o && !tag_req_o && !burst_req_o, "R11 reset outputs",
        {run_o, irq_o, tag_req_o, burst_req_o}, 0);
    chk(stall_addr_o == 32'h0, "R11 reset stall", stall_addr_o, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    run_seq(0, 0, 0, 0, 0, 16'd3, 32'h100, 32'h8000, 0, 1, "R9 normal burst");
    run_seq(0, 0, 0, 0, 0, 16'd0, 32'h100, 32'h8000, 0, 0, "R9 normal zero");
    run_seq(1, 0, 0, 0, 0, 16'd2, 32'h200, 32'h9000, 0, 1, "R1 preloaded chain");

    for (int e = 0; e < 3; e++) begin
      for (int s = 0; s < 2; s++) begin
        set_tag(0, 3'd1, 1'b0, 16'd1 + 16'(e), 32'h1000 + 32'(e * 64));
        set_tag(1, 3'd0, 1'b0, 16'd2 + 16'(s), 32'h2000 + 32'(s * 128 + e * 16));
        set_tag(2, (e == 0) ? 3'd7 : ((e == 1) ? 3'd3 : 3'd5), 1'b0, 16'd3, 32'h3000);
        run_seq(1, 0, s[0], 0, 0, 16'd0, 32'h400 + 32'(e * 256), 32'h0, 3, 3, "R4 chain end by ID");
      end
    end

    for (int t = 0; t < 2; t++) begin
      set_tag(0, 3'd1, 1'b1, 16'd2, 32'h5000);
      set_tag(1, 3'd7, 1'b0, 16'd1, 32'h6000);
      run_seq(1, t[0], 0, 0, 0, 16'd0, 32'h800, 32'h0, t ? 1 : 2, t ? 1 : 2, "R6 tag interrupt end");
    end

    set_tag(0, 3'd0, 1'b0, 16'd4, 32'h7000);
    set_tag(1, 3'd1, 1'b0, 16'd1, 32'h7100);
    set_tag(2, 3'd7, 1'b1, 16'd2, 32'h7200);
    run_seq(1, 1, 1, 1, 1, 16'd0, 32'hC00, 32'h0, 3, 3, "R10 restart ignored");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule